// File: doc/BRIEF.md
# Debug Port Command Sequencer

This block is the control sequencer of an on-chip debug port. While the chip runs normally it waits. Once debug mode is requested, it collects an 8-bit command from an external controller one bit per shift strobe and decodes that command in two pipeline stages. It then carries out one of three kinds of work. It can shift a 16-bit word into or out of a debug register. It can clear the breakpoint or trace counter. Or it can take a 16-bit instruction word into the program-data-bus holding register and ask the core to execute it.

Execution requests come in several forms: one-word or two-word, and with debug mode kept or left. For a two-word instruction, the first word is parked on the program data bus, and the sequencer goes back to fetch a second command and word before it raises the request. When debug mode is kept, the sequencer does not take the next command until the core reports that the instruction has finished.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle), and every pulse output (`reg_wr`, `ack_pulse`, `clr_bkpt`, `clr_trace`, `repeat_req`, `pdb_load`, `exec_req`, `exit_debug`) is low.
- R2: In idle (`state_o`=0), the sequencer stays idle while `debug_req` is low. If `debug_req` is high at an edge, it moves to command fetch (`state_o`=1) on that edge.
- R3: In command fetch, each strobe shifts `shift_din` in MSB first. On the 8th strobe the byte is captured and the state becomes 2 (first decode). Byte layout: bit 7 = read (1) or write (0), bit 6 = go, bit 5 = leave debug, bits 4:0 = select.
- R4: In first decode, a command with go=1 and a select other than 5'h09 accesses no register. It pulses `repeat_req` for one cycle and returns to command fetch.
- R5: In first decode, select 5'h0A (go=0) pulses `clr_bkpt` and select 5'h0B (go=0) pulses `clr_trace`. Either one returns to command fetch without any data shift, and the two pulses are never high together.
- R6: The first decode state lasts exactly one cycle. All other commands go to second decode (`state_o`=3), which lasts one cycle. A write to select 5'h09 then goes to the holding-write state (`state_o`=5). Every other command goes to register transfer (`state_o`=4); reserved selects 5'h0C to 5'h1F count as plain register accesses.
- R7: In register transfer, 16 strobes move one word, and the sequencer then returns to command fetch. A write ends with `reg_wr` and `ack_pulse` in the same cycle, with `reg_sel` and the received word on `reg_wdata`. A read shifts out, MSB first on `shift_dout`, the word sampled on entry: `reg_rdata`, or the holding register when the select is 5'h09. A read raises neither pulse.
- R8: In the holding-write state, 16 strobes receive a word. When go=0, this pulses `pdb_load` with the word on `pdb_word`, marks a two-word instruction as pending and returns to command fetch without an execute request.
- R9: When go=1 and leave=0, the completed word pulses `pdb_load` and `exec_req` together. `exec_two_word` is 1 exactly when a first word was pending, and the pending mark is then cleared. The state remains 5 until `core_done` is high at an edge, after which it is 1.
- R10: When go=1 and leave=1, the completed word pulses `pdb_load`, `exec_req` and `exit_debug` together, and the state returns to idle (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| debug_req | input | 1 | Chip is in or requests debug mode |
| shift_strobe | input | 1 | One serial bit is valid this cycle |
| shift_din | input | 1 | Serial data in |
| shift_dout | output | 1 | Serial data out (MSB of the shift register) |
| core_done | input | 1 | Core finished the requested instruction |
| reg_rdata | input | 16 | Read data of the selected debug register |
| reg_sel | output | 5 | Select field of the current command |
| reg_wr | output | 1 | Debug register write strobe |
| reg_wdata | output | 16 | Debug register write data |
| ack_pulse | output | 1 | One-cycle acknowledge after a register write |
| clr_bkpt | output | 1 | Clear the breakpoint counter |
| clr_trace | output | 1 | Clear the trace counter |
| repeat_req | output | 1 | Core re-executes its previous instruction |
| pdb_load | output | 1 | Holding register word transferred to the program data bus |
| pdb_word | output | 16 | Holding register contents |
| exec_req | output | 1 | Core execute request |
| exec_two_word | output | 1 | Execute request is for a two-word instruction |
| exit_debug | output | 1 | Leave debug mode with this execute |
| state_o | output | 3 | Current sequencer state |

## Verification
The bound checker watches the legal state moves on every cycle. Idle is held or left according to `debug_req`, and each decode stage lasts a single cycle and leads only to its allowed successors. It also checks that the pulses are consistent with one another: an acknowledge only with a write, an execute only with a holding-register load, a mode exit only with an execute and a return to idle, and the two counter clears never together. The bench scenarios are what show the payloads. These include the MSB-first assembly of the command and data words, the word shifted out on reads including holding-register readback, the one-word versus two-word flag carried across two commands, and the wait for `core_done`.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  localparam int CMD_W = 8;
  localparam int SEL_W = 5;

  localparam logic [SEL_W-1:0] SEL_HOLD      = 5'h09;
  localparam logic [SEL_W-1:0] SEL_CLR_BKPT  = 5'h0A;
  localparam logic [SEL_W-1:0] SEL_CLR_TRACE = 5'h0B;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_POLL     = 3'd1,
    ST_DEC_A    = 3'd2,
    ST_DEC_B    = 3'd3,
    ST_REG_XFER = 3'd4,
    ST_HOLD_WR  = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic             rd;
    logic             go;
    logic             leave;
    logic [SEL_W-1:0] sel;
    logic             hold;
    logic             clr_b;
    logic             clr_t;
  } cmd_dec_t;

endpackage

// File: rtl/dbg_bit_cnt.sv
module dbg_bit_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (clr)      cnt_n = '0;
    else if (inc) cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || inc) cnt <= cnt_n;
  end
endmodule

// File: rtl/dbg_shift_reg.sv
module dbg_shift_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load)     q <= load_val;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_seq_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output cmd_dec_t         dec
);
  always_comb begin
    dec.rd    = cmd[7];
    dec.go    = cmd[6];
    dec.leave = cmd[5];
    dec.sel   = cmd[SEL_W-1:0];
    dec.hold  = (cmd[SEL_W-1:0] == SEL_HOLD);
    dec.clr_b = (cmd[SEL_W-1:0] == SEL_CLR_BKPT);
    dec.clr_t = (cmd[SEL_W-1:0] == SEL_CLR_TRACE);
  end
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              debug_req,
  input  logic              shift_strobe,
  input  logic              shift_din,
  output logic              shift_dout,
  input  logic              core_done,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [SEL_W-1:0]  reg_sel,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              ack_pulse,
  output logic              clr_bkpt,
  output logic              clr_trace,
  output logic              repeat_req,
  output logic              pdb_load,
  output logic [DATA_W-1:0] pdb_word,
  output logic              exec_req,
  output logic              exec_two_word,
  output logic              exit_debug,
  output logic [2:0]        state_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  seq_state_t        state_q, state_n;
  logic [CMD_W-1:0]  cmd_q;
  cmd_dec_t          dec;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_clr, cnt_inc;
  logic [DATA_W-1:0] sh_q;
  logic              sh_en, sh_load;
  logic [DATA_W-1:0] sh_load_val;
  logic [DATA_W-1:0] word_n;
  logic              cmd_ld;
  logic              pend_q, pend_set, pend_clr;
  logic              wait_q, wait_set, wait_clr;
  logic              regwr_n, ack_n, clrb_n, clrt_n, rep_n;
  logic              load_n, exec_n, two_n, exit_n;
  logic              last_cmd_bit, last_data_bit;

  dbg_bit_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  dbg_shift_reg #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_load_val),
    .shift_en(sh_en), .din(shift_din), .q(sh_q)
  );

  dbg_cmd_decode u_dec (.cmd(cmd_q), .dec(dec));

  assign last_cmd_bit  = (cnt == CMD_LAST);
  assign last_data_bit = (cnt == DATA_LAST);
  assign word_n        = {sh_q[DATA_W-2:0], shift_din};
  assign sh_load_val   = dec.hold ? pdb_word : reg_rdata;

  // next-state and control decode
  always_comb begin
    state_n  = state_q;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    sh_en    = 1'b0;
    sh_load  = 1'b0;
    cmd_ld   = 1'b0;
    pend_set = 1'b0;
    pend_clr = 1'b0;
    wait_set = 1'b0;
    wait_clr = 1'b0;
    regwr_n  = 1'b0;
    ack_n    = 1'b0;
    clrb_n   = 1'b0;
    clrt_n   = 1'b0;
    rep_n    = 1'b0;
    load_n   = 1'b0;
    exec_n   = 1'b0;
    two_n    = 1'b0;
    exit_n   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (debug_req) state_n = ST_POLL;
      end
      ST_POLL: begin
        if (shift_strobe) begin
          sh_en   = 1'b1;
          cnt_inc = 1'b1;
          if (last_cmd_bit) begin
            cmd_ld  = 1'b1;
            cnt_clr = 1'b1;
            state_n = ST_DEC_A;
          end
        end
      end
      ST_DEC_A: begin
        if (dec.go && !dec.hold) begin
          rep_n   = 1'b1;
          state_n = ST_POLL;
        end else if (dec.clr_b) begin
          clrb_n  = 1'b1;
          state_n = ST_POLL;
        end else if (dec.clr_t) begin
          clrt_n  = 1'b1;
          state_n = ST_POLL;
        end else begin
          state_n = ST_DEC_B;
        end
      end
      ST_DEC_B: begin
        cnt_clr = 1'b1;
        if (dec.hold && !dec.rd) begin
          state_n = ST_HOLD_WR;
        end else begin
          state_n = ST_REG_XFER;
          sh_load = dec.rd;
        end
      end
      ST_REG_XFER: begin
        if (shift_strobe) begin
          sh_en   = 1'b1;
          cnt_inc = 1'b1;
          if (last_data_bit) begin
            cnt_clr = 1'b1;
            state_n = ST_POLL;
            regwr_n = !dec.rd;
            ack_n   = !dec.rd;
          end
        end
      end
      ST_HOLD_WR: begin
        if (wait_q) begin
          if (core_done) begin
            wait_clr = 1'b1;
            state_n  = ST_POLL;
          end
        end else if (shift_strobe) begin
          sh_en   = 1'b1;
          cnt_inc = 1'b1;
          if (last_data_bit) begin
            cnt_clr = 1'b1;
            load_n  = 1'b1;
            if (!dec.go) begin
              pend_set = 1'b1;
              state_n  = ST_POLL;
            end else begin
              exec_n   = 1'b1;
              two_n    = pend_q;
              pend_clr = 1'b1;
              if (dec.leave) begin
                exit_n  = 1'b1;
                state_n = ST_IDLE;
              end else begin
                wait_set = 1'b1;
              end
            end
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // state and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (pend_set)      pend_q <= 1'b1;
      else if (pend_clr) pend_q <= 1'b0;
      if (wait_set)      wait_q <= 1'b1;
      else if (wait_clr) wait_q <= 1'b0;
    end
  end

  // command and data holding registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      reg_wdata <= '0;
      pdb_word  <= '0;
    end else begin
      if (cmd_ld)  cmd_q     <= word_n[CMD_W-1:0];
      if (regwr_n) reg_wdata <= word_n;
      if (load_n)  pdb_word  <= word_n;
    end
  end

  // registered pulse outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr        <= 1'b0;
      ack_pulse     <= 1'b0;
      clr_bkpt      <= 1'b0;
      clr_trace     <= 1'b0;
      repeat_req    <= 1'b0;
      pdb_load      <= 1'b0;
      exec_req      <= 1'b0;
      exec_two_word <= 1'b0;
      exit_debug    <= 1'b0;
    end else begin
      reg_wr        <= regwr_n;
      ack_pulse     <= ack_n;
      clr_bkpt      <= clrb_n;
      clr_trace     <= clrt_n;
      repeat_req    <= rep_n;
      pdb_load      <= load_n;
      exec_req      <= exec_n;
      exec_two_word <= two_n;
      exit_debug    <= exit_n;
    end
  end

  assign reg_sel    = dec.sel;
  assign shift_dout = sh_q[DATA_W-1];
  assign state_o    = state_q;

endmodule

// File: rtl/dbg_cmd_seq_chk.sv
module dbg_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       debug_req,
  input logic [2:0] state_o,
  input logic       reg_wr,
  input logic       ack_pulse,
  input logic       clr_bkpt,
  input logic       clr_trace,
  input logic       pdb_load,
  input logic       exec_req,
  input logic       exit_debug
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && !debug_req) |=> state_o == 3'd0);

  a_r2_enter_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && debug_req) |=> state_o == 3'd1);

  a_r6_dec_a_single: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd2 |=> (state_o == 3'd1 || state_o == 3'd3));

  a_r6_dec_b_target: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 3'd3 |=> (state_o == 3'd4 || state_o == 3'd5));

  a_r7_ack_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |-> reg_wr);

  a_r5_clr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_bkpt && clr_trace));

  a_r9_exec_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req |-> pdb_load);

  a_r10_exit_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    exit_debug |-> (exec_req && state_o == 3'd0));
endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk u_chk (.*);

// File: tb/tb_dbg_cmd_seq.sv
module tb_dbg_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        debug_req = 1'b0;
  logic        shift_strobe = 1'b0;
  logic        shift_din = 1'b0;
  logic        shift_dout;
  logic        core_done = 1'b0;
  logic [15:0] reg_rdata;
  logic [4:0]  reg_sel;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic        ack_pulse, clr_bkpt, clr_trace, repeat_req, pdb_load;
  logic [15:0] pdb_word;
  logic        exec_req, exec_two_word, exit_debug;
  logic [2:0]  state_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] expq[$];

  localparam logic [7:0] K_REP = 8'd1, K_CLRB = 8'd2, K_CLRT = 8'd3, K_WR = 8'd4,
                         K_ACK = 8'd5, K_PDB = 8'd6, K_EX1 = 8'd7, K_EX2 = 8'd8,
                         K_EXIT = 8'd9;

  always #4 clk = ~clk;

  assign reg_rdata = {reg_sel, 11'h2A5};

  dbg_cmd_seq dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_evt(input logic [7:0] k, input logic [7:0] s, input logic [15:0] d);
    expq.push_back({k, s, d});
  endtask

  task automatic see_evt(input logic [31:0] code);
    logic [31:0] e;
    if (expq.size() == 0) begin
      chk(1'b0, "event unexpected", code, 32'h0);
    end else begin
      e = expq.pop_front();
      chk(code == e, "event order/payload", code, e);
    end
  endtask

  // monitor: pops expectations as pulses appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (repeat_req) see_evt({K_REP, 8'h0, 16'h0});
      if (clr_bkpt)   see_evt({K_CLRB, 8'h0, 16'h0});
      if (clr_trace)  see_evt({K_CLRT, 8'h0, 16'h0});
      if (reg_wr)     see_evt({K_WR, 3'b0, reg_sel, reg_wdata});
      if (ack_pulse)  see_evt({K_ACK, 8'h0, 16'h0});
      if (pdb_load)   see_evt({K_PDB, 8'h0, pdb_word});
      if (exec_req)   see_evt({exec_two_word ? K_EX2 : K_EX1, 8'h0, 16'h0});
      if (exit_debug) see_evt({K_EXIT, 8'h0, 16'h0});
    end
  end

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      shift_din = v[i];
      shift_strobe = 1'b1;
      @(negedge clk);
      shift_strobe = 1'b0;
    end
  endtask

  task automatic recv_word(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      w[i] = shift_dout;
      shift_strobe = 1'b1;
      @(negedge clk);
      shift_strobe = 1'b0;
    end
  endtask

  task automatic wait_state(input logic [2:0] s, input string tag);
    int n = 0;
    while (state_o != s && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(state_o == s, tag, {29'b0, state_o}, {29'b0, s});
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(state_o == 3'd0, "R1 state", {29'b0, state_o}, 32'd0);
    chk({reg_wr, ack_pulse, clr_bkpt, clr_trace, repeat_req, pdb_load, exec_req, exit_debug} == 8'h0,
        "R1 pulses", {24'b0, reg_wr, ack_pulse, clr_bkpt, clr_trace, repeat_req, pdb_load, exec_req, exit_debug}, 32'd0);
    // R2: idle holds, then enters fetch
    repeat (3) @(negedge clk);
    chk(state_o == 3'd0, "R2 idle hold", {29'b0, state_o}, 32'd0);
    debug_req = 1'b1;
    @(negedge clk);
    chk(state_o == 3'd1, "R2 enter fetch", {29'b0, state_o}, 32'd1);

    // R3 + R7: write register 3
    send_bits(16'h03, 8);
    chk(state_o == 3'd2, "R3 first decode", {29'b0, state_o}, 32'd2);
    wait_state(3'd4, "R6 write to transfer");
    expect_evt(K_WR, 8'h03, 16'hA5C3);
    expect_evt(K_ACK, 8'h0, 16'h0);
    send_bits(16'hA5C3, 16);
    chk(state_o == 3'd1, "R7 back to fetch", {29'b0, state_o}, 32'd1);

    // R7: read register 5, no ack
    send_bits(16'h85, 8);
    wait_state(3'd4, "R6 read to transfer");
    recv_word(got);
    chk(got == {5'h05, 11'h2A5}, "R7 read word", {16'b0, got}, {16'b0, 5'h05, 11'h2A5});
    chk(state_o == 3'd1, "R7 read done", {29'b0, state_o}, 32'd1);

    // R5: counter clears
    expect_evt(K_CLRB, 8'h0, 16'h0);
    send_bits(16'h0A, 8);
    wait_state(3'd1, "R5 clr bkpt back to fetch");
    expect_evt(K_CLRT, 8'h0, 16'h0);
    send_bits(16'h0B, 8);
    wait_state(3'd1, "R5 clr trace back to fetch");

    // R4: repeat previous instruction
    expect_evt(K_REP, 8'h0, 16'h0);
    send_bits(16'h43, 8);
    wait_state(3'd1, "R4 repeat back to fetch");

    // R6: reserved select behaves as plain write
    send_bits(16'h1C, 8);
    wait_state(3'd4, "R6 reserved to transfer");
    expect_evt(K_WR, 8'h1C, 16'h1234);
    expect_evt(K_ACK, 8'h0, 16'h0);
    send_bits(16'h1234, 16);

    // R9: one-word execute, wait for core
    send_bits(16'h49, 8);
    wait_state(3'd5, "R6 hold write state");
    expect_evt(K_PDB, 8'h0, 16'hBEEF);
    expect_evt(K_EX1, 8'h0, 16'h0);
    send_bits(16'hBEEF, 16);
    repeat (4) @(negedge clk);
    chk(state_o == 3'd5, "R9 waits for core", {29'b0, state_o}, 32'd5);
    core_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
    chk(state_o == 3'd1, "R9 done to fetch", {29'b0, state_o}, 32'd1);

    // R8: first word of two-word instruction
    send_bits(16'h09, 8);
    wait_state(3'd5, "R8 hold write state");
    expect_evt(K_PDB, 8'h0, 16'h1111);
    send_bits(16'h1111, 16);
    chk(state_o == 3'd1, "R8 back to fetch", {29'b0, state_o}, 32'd1);
    // R9: second word completes a two-word execute
    send_bits(16'h49, 8);
    wait_state(3'd5, "R9 second word state");
    expect_evt(K_PDB, 8'h0, 16'h2222);
    expect_evt(K_EX2, 8'h0, 16'h0);
    send_bits(16'h2222, 16);
    core_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
    chk(state_o == 3'd1, "R9 two-word done", {29'b0, state_o}, 32'd1);

    // R7: holding register readback
    send_bits(16'h89, 8);
    wait_state(3'd4, "R7 hold read transfer");
    recv_word(got);
    chk(got == 16'h2222, "R7 hold readback", {16'b0, got}, 32'h2222);

    // R10: execute and leave debug mode (pending was cleared, so one-word)
    send_bits(16'h69, 8);
    wait_state(3'd5, "R10 hold write state");
    debug_req = 1'b0;
    expect_evt(K_PDB, 8'h0, 16'h7777);
    expect_evt(K_EX1, 8'h0, 16'h0);
    expect_evt(K_EXIT, 8'h0, 16'h0);
    send_bits(16'h7777, 16);
    chk(state_o == 3'd0, "R10 back to idle", {29'b0, state_o}, 32'd0);
    repeat (3) @(negedge clk);
    chk(state_o == 3'd0, "R2 idle after exit", {29'b0, state_o}, 32'd0);
    chk(expq.size() == 0, "R7 R9 all events seen", expq.size(), 32'd0);
    finish_run();
  end
endmodule